// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block connects a single-clock request port to an external asynchronous static RAM that holds 262,144 words of 16 bits and takes an 18-bit word address. A requester presents a request with a write flag, an address, write data and a two-bit byte mask. The block accepts the request only while it is idle. It then drives the active-low chip-enable, output-enable, write-enable and per-byte select strobes. It also drives the shared data bus through an output-enable for the tri-state pad. When the access ends it returns a one-cycle done pulse, and for reads it also returns the captured data.

The memory has no clock, so every minimum time it needs is met by holding a phase for a counted number of clock cycles. Each count is the required time in nanoseconds divided by the clock-period parameter, rounded up, and never less than one. A read keeps the strobes steady for the whole access time and captures the bus on its last cycle. A write first holds output-enable high long enough for the memory to float its outputs. Only then does it pull write-enable low and drive the data. It releases the bus one cycle after write-enable rises. The figures below use the default 8 ns clock.

Top module: `sram_lane_ctrl`

## Requirements
- R1: Out of reset and whenever no access is in progress, req_ready is 1, rsp_done is 0, sram_ce_n, sram_oe_n and sram_we_n are 1, both bits of sram_bsel_n are 1 and sram_dq_oe is 0.
- R2: A request is taken at a clock edge only if req_valid and req_ready are both 1 there. req_ready is 0 from the cycle after that edge until the access completes, and a request held during that time is not taken until req_ready returns.
- R3: A read drives sram_ce_n=0, sram_oe_n=0 and sram_we_n=1 for exactly RD_CYC consecutive cycles (9 at the defaults: 70 ns over 8 ns), starting in the cycle after the request is taken.
- R4: On the last read cycle sram_dq_in is captured into rsp_rdata. rsp_done is 1 for exactly the next cycle, and rsp_rdata changes only in a cycle where rsp_done is 1.
- R5: Mask bit 0 selects the lower byte (data bits 7:0) through sram_bsel_n[0], and mask bit 1 selects the upper byte (bits 15:8) through sram_bsel_n[1]. During an access a lane's select is 0 when its mask bit is 1, and it stays at 1 otherwise.
- R6: On a read, the byte of rsp_rdata whose mask bit is 0 returns zero, whatever is on the bus.
- R7: A write first holds sram_ce_n=0, sram_oe_n=1 and sram_we_n=1 with sram_dq_oe=0 for TA_CYC cycles (4 at the defaults: 25 ns).
- R8: Next, sram_we_n is 0 for exactly WP_CYC cycles (9 at the defaults: the longest of 55, 65 and 30 ns). During those cycles sram_dq_oe is 1 and sram_dq_out carries the request's write data.
- R9: sram_dq_oe stays 1 for the one cycle after sram_we_n rises and is 0 after that. rsp_done is 1 in the cycle after the release.
- R10: sram_addr holds the request's address, unchanged, for every cycle in which sram_ce_n is 0.
- R11: sram_oe_n and sram_we_n are never 0 together, and sram_dq_oe is never 1 while sram_oe_n is 0.
- R12: A request with mask 00 still runs its full sequence and completes, but both byte selects stay at 1. Such a write leaves the memory contents unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte mask, bit 0 lower byte, bit 1 upper byte |
| req_ready | output | 1 | Block idle, request may be taken |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Captured read data |
| sram_addr | output | 18 | Memory address |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_bsel_n | output | 2 | Byte selects, active low, bit 0 lower |
| sram_dq_out | output | 16 | Data toward the bus pad |
| sram_dq_oe | output | 1 | Pad driver enable |
| sram_dq_in | input | 16 | Data from the bus pad |

## Verification
If a request is taken at edge k, the strobes change in the cycle after k. A read's data and done pulse appear 10 cycles after k (9 access cycles plus one). A write's done pulse appears 15 cycles after k: 4 turnaround cycles, 9 pulse cycles, 1 release cycle and one more. The bench tracks the cycle index since acceptance in its own model. At every falling edge it compares each port against the value that index implies, so a phase that is one cycle early or late fails on the first cycle that differs.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_READ   = 3'd1,
    PH_TURN   = 3'd2,
    PH_WPULSE = 3'd3,
    PH_WREC   = 3'd4
  } phase_e;

  // whole cycles covering a time in ns, never below one
  function automatic int unsigned ns_to_cycles(input int unsigned t_ns,
                                               input int unsigned clk_ns);
    int unsigned c;
    c = (t_ns + clk_ns - 1) / clk_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // width of a counter that must reach value n
  function automatic int unsigned cnt_bits(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_lane_pkg::*;
#(
  parameter int unsigned RD_CYC = 9,
  parameter int unsigned TA_CYC = 4,
  parameter int unsigned WP_CYC = 9,
  parameter int unsigned CNT_W  = 4
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   start_write,
  output phase_e phase,
  output logic   phase_last,
  output logic   done
);

  logic [CNT_W-1:0] cnt;

  always_comb begin
    case (phase)
      PH_READ:   phase_last = (cnt == CNT_W'(RD_CYC - 1));
      PH_TURN:   phase_last = (cnt == CNT_W'(TA_CYC - 1));
      PH_WPULSE: phase_last = (cnt == CNT_W'(WP_CYC - 1));
      PH_WREC:   phase_last = 1'b1;
      default:   phase_last = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (phase == PH_IDLE) begin
        cnt <= '0;
        if (start) phase <= start_write ? PH_TURN : PH_READ;
      end else if (phase_last) begin
        cnt <= '0;
        case (phase)
          PH_READ:   begin phase <= PH_IDLE; done <= 1'b1; end
          PH_TURN:   phase <= PH_WPULSE;
          PH_WPULSE: phase <= PH_WREC;
          PH_WREC:   begin phase <= PH_IDLE; done <= 1'b1; end
          default:   phase <= PH_IDLE;
        endcase
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/sram_byte_lane.sv
module sram_byte_lane #(
  parameter int unsigned LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lane_en,
  input  logic              cycle_active,
  input  logic              capture,
  input  logic [LANE_W-1:0] bus_in,
  output logic              bsel_n,
  output logic [LANE_W-1:0] rd_byte
);

  assign bsel_n = !(cycle_active && lane_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rd_byte <= '0;
    else if (capture) rd_byte <= lane_en ? bus_in : '0;
  end

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int unsigned ADDR_W   = 18,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned CLK_NS   = 8,
  parameter int unsigned T_RC_NS  = 70,
  parameter int unsigned T_AA_NS  = 70,
  parameter int unsigned T_OE_NS  = 35,
  parameter int unsigned T_WC_NS  = 70,
  parameter int unsigned T_WP_NS  = 55,
  parameter int unsigned T_AW_NS  = 65,
  parameter int unsigned T_DS_NS  = 30,
  parameter int unsigned T_HZ_NS  = 25
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [DATA_W-1:0]    req_wdata,
  input  logic [DATA_W/8-1:0]  req_be,
  output logic                 req_ready,
  output logic                 rsp_done,
  output logic [DATA_W-1:0]    rsp_rdata,
  output logic [ADDR_W-1:0]    sram_addr,
  output logic                 sram_ce_n,
  output logic                 sram_oe_n,
  output logic                 sram_we_n,
  output logic [DATA_W/8-1:0]  sram_bsel_n,
  output logic [DATA_W-1:0]    sram_dq_out,
  output logic                 sram_dq_oe,
  input  logic [DATA_W-1:0]    sram_dq_in
);

  localparam int unsigned LANES  = DATA_W / 8;
  localparam int unsigned RD_CYC = max2(max2(ns_to_cycles(T_RC_NS, CLK_NS),
                                             ns_to_cycles(T_AA_NS, CLK_NS)),
                                        ns_to_cycles(T_OE_NS, CLK_NS));
  localparam int unsigned TA_CYC = ns_to_cycles(T_HZ_NS, CLK_NS);
  localparam int unsigned WC_CYC = ns_to_cycles(T_WC_NS, CLK_NS);
  // pulse covers width, address-to-end, data setup and the whole write cycle
  localparam int unsigned WP_MIN = max2(max2(ns_to_cycles(T_WP_NS, CLK_NS),
                                             ns_to_cycles(T_AW_NS, CLK_NS)),
                                        ns_to_cycles(T_DS_NS, CLK_NS));
  localparam int unsigned WP_CYC = (WC_CYC > TA_CYC + WP_MIN + 1)
                                   ? (WC_CYC - TA_CYC - 1) : WP_MIN;
  localparam int unsigned CNT_W  = cnt_bits(max2(max2(RD_CYC, TA_CYC), WP_CYC));

  // named internal events
  phase_e             phase;
  logic               phase_last;
  logic               accept;
  logic               rd_capture;
  logic               wr_end;
  logic               cycle_active;

  logic [ADDR_W-1:0]  addr_q;
  logic [DATA_W-1:0]  wdata_q;
  logic [LANES-1:0]   be_q;

  assign req_ready    = (phase == PH_IDLE);
  assign accept       = req_valid && req_ready;
  assign rd_capture   = (phase == PH_READ) && phase_last;
  assign wr_end       = (phase == PH_WPULSE) && phase_last;
  assign cycle_active = (phase != PH_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      be_q    <= req_be;
    end
  end

  sram_seq_fsm #(
    .RD_CYC(RD_CYC),
    .TA_CYC(TA_CYC),
    .WP_CYC(WP_CYC),
    .CNT_W (CNT_W)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (accept),
    .start_write(req_write),
    .phase      (phase),
    .phase_last (phase_last),
    .done       (rsp_done)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sram_byte_lane #(.LANE_W(8)) u_lane (
      .clk         (clk),
      .rst_n       (rst_n),
      .lane_en     (be_q[g]),
      .cycle_active(cycle_active),
      .capture     (rd_capture),
      .bus_in      (sram_dq_in[g*8 +: 8]),
      .bsel_n      (sram_bsel_n[g]),
      .rd_byte     (rsp_rdata[g*8 +: 8])
    );
  end

  assign sram_addr   = addr_q;
  assign sram_ce_n   = !cycle_active;
  assign sram_oe_n   = (phase != PH_READ);
  assign sram_we_n   = (phase != PH_WPULSE);
  assign sram_dq_oe  = (phase == PH_WPULSE) || (phase == PH_WREC);
  assign sram_dq_out = wdata_q;

endmodule

// File: rtl/sram_lane_ctrl_chk.sv
module sram_lane_ctrl_chk #(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned RD_CYC = 9,
  parameter int unsigned TA_CYC = 4,
  parameter int unsigned WP_CYC = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_done,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic [ADDR_W-1:0] sram_addr,
  input logic              sram_ce_n,
  input logic              sram_oe_n,
  input logic              sram_we_n,
  input logic              sram_dq_oe,
  input logic              rd_capture,
  input logic              wr_end
);

  localparam logic [15:0] RD_L = 16'(RD_CYC);
  localparam logic [15:0] TA_L = 16'(TA_CYC);
  localparam logic [15:0] WP_L = 16'(WP_CYC);

  logic [15:0] we_lo_cnt;
  logic [15:0] oe_lo_cnt;
  logic [15:0] turn_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_lo_cnt <= '0;
      oe_lo_cnt <= '0;
      turn_cnt  <= '0;
    end else begin
      we_lo_cnt <= !sram_we_n ? ((we_lo_cnt == 16'hFFFF) ? we_lo_cnt : we_lo_cnt + 1'b1) : '0;
      oe_lo_cnt <= !sram_oe_n ? ((oe_lo_cnt == 16'hFFFF) ? oe_lo_cnt : oe_lo_cnt + 1'b1) : '0;
      turn_cnt  <= (!sram_ce_n && sram_oe_n && !sram_dq_oe)
                   ? ((turn_cnt == 16'hFFFF) ? turn_cnt : turn_cnt + 1'b1) : '0;
    end
  end

  AST_OE_WE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> sram_oe_n); // R11
  AST_NO_DRIVE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    sram_dq_oe |-> sram_oe_n); // R11
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> sram_ce_n); // R2
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done); // R4
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rsp_rdata) |-> rsp_done); // R4
  AST_CAPTURE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_capture |=> rsp_done); // R4
  AST_READ_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_oe_n) |-> (oe_lo_cnt == RD_L)); // R3
  AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_dq_oe) |-> (turn_cnt >= TA_L)); // R7
  AST_WE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> sram_dq_oe); // R8
  AST_WE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> (we_lo_cnt == WP_L)); // R8
  AST_WR_END_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_end |=> (sram_we_n && sram_dq_oe)); // R9
  AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |=> !sram_dq_oe); // R9
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_ce_n && $past(!sram_ce_n)) |-> $stable(sram_addr)); // R10

endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W),
  .RD_CYC(RD_CYC),
  .TA_CYC(TA_CYC),
  .WP_CYC(WP_CYC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_done  (rsp_done),
  .rsp_rdata (rsp_rdata),
  .sram_addr (sram_addr),
  .sram_ce_n (sram_ce_n),
  .sram_oe_n (sram_oe_n),
  .sram_we_n (sram_we_n),
  .sram_dq_oe(sram_dq_oe),
  .rd_capture(rd_capture),
  .wr_end    (wr_end)
);

// File: tb/sram_lane_ctrl_tb.sv
`timescale 1ns/1ps
module sram_lane_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [17:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        req_ready, rsp_done;
  logic [15:0] rsp_rdata;
  logic [17:0] sram_addr;
  logic        sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe;
  logic [1:0]  sram_bsel_n;
  logic [15:0] sram_dq_out;
  logic [15:0] sram_dq_in = 16'h5A5A;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  sram_lane_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .req_ready(req_ready), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n),
    .sram_we_n(sram_we_n), .sram_bsel_n(sram_bsel_n), .sram_dq_out(sram_dq_out),
    .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
  );

  // phase lengths worked out from the timing figures at 8 ns per cycle
  function automatic int span(input int ns);
    int c = 0;
    while (c * 8 < ns) c++;
    return (c == 0) ? 1 : c;
  endfunction
  int RDC, TAC, WPC;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  // external memory model and independent shadow of intended contents
  logic [15:0] mem    [int];
  logic [15:0] shadow [int];

  function automatic logic [15:0] rd_word(input logic [15:0] arr [int], input int a);
    return arr.exists(a) ? arr[a] : 16'h0000;
  endfunction

  // reference model state
  int          m_op = 0;   // 0 idle, 1 read, 2 write
  int          m_t = 0;
  logic [17:0] ma;
  logic [15:0] md, m_exp;
  logic [1:0]  mb;
  bit          prev_ready = 1'b1;
  bit          pv = 1'b0, pw = 1'b0;
  logic [17:0] pa;
  logic [15:0] pd;
  logic [1:0]  pb;
  logic        prev_we_n = 1'b1;

  always @(negedge clk) begin
    bit e_ready, e_done, e_ce, e_oe, e_we, e_oe_drv;
    logic [1:0] e_bsel;
    int done_idx;
    string ctag;
    // memory model writes on the rising write strobe
    if (rst_n && !prev_we_n && sram_we_n && !sram_ce_n) begin
      logic [15:0] w;
      chk(sram_dq_oe == 1'b1, "R9 driver at write end", {31'd0, sram_dq_oe}, 32'd1);
      w = rd_word(mem, int'(sram_addr));
      if (!sram_bsel_n[0]) w[7:0]  = sram_dq_out[7:0];
      if (!sram_bsel_n[1]) w[15:8] = sram_dq_out[15:8];
      mem[int'(sram_addr)] = w;
    end
    prev_we_n = sram_we_n;

    if (!rst_n) begin
      m_op = 0; prev_ready = 1'b1; pv = 1'b0;
    end else if (pv && prev_ready) begin
      m_op = pw ? 2 : 1; m_t = 0; ma = pa; md = pd; mb = pb;
      if (pw) begin
        logic [15:0] s;
        s = rd_word(shadow, int'(pa));
        if (pb[0]) s[7:0]  = pd[7:0];
        if (pb[1]) s[15:8] = pd[15:8];
        shadow[int'(pa)] = s;
      end else begin
        m_exp = rd_word(shadow, int'(pa)) & {{8{pb[1]}}, {8{pb[0]}}};
      end
    end else if (m_op != 0) begin
      m_t++;
      done_idx = (m_op == 1) ? RDC : TAC + WPC + 1;
      if (m_t > done_idx) m_op = 0;
    end

    e_ready = 1; e_done = 0; e_ce = 1; e_oe = 1; e_we = 1; e_oe_drv = 0; e_bsel = 2'b11;
    ctag = "R1";
    if (m_op == 1) begin
      ctag = "R3";
      if (m_t < RDC) begin
        e_ready = 0; e_ce = 0; e_oe = 0; e_bsel = ~mb;
      end else e_done = 1;
    end else if (m_op == 2) begin
      ctag = "R7";
      if (m_t < TAC + WPC + 1) begin
        e_ready = 0; e_ce = 0; e_bsel = ~mb;
      end
      if (m_t >= TAC && m_t < TAC + WPC) begin e_we = 0; e_oe_drv = 1; ctag = "R8"; end
      if (m_t == TAC + WPC) begin e_oe_drv = 1; ctag = "R9"; end
      if (m_t == TAC + WPC + 1) begin e_done = 1; ctag = "R9"; end
    end

    chk(req_ready == e_ready, "R2 req_ready", {31'd0, req_ready}, {31'd0, e_ready});
    chk(rsp_done == e_done, {ctag, " rsp_done"}, {31'd0, rsp_done}, {31'd0, e_done});
    chk(sram_ce_n == e_ce, {ctag, " ce_n"}, {31'd0, sram_ce_n}, {31'd0, e_ce});
    chk(sram_oe_n == e_oe, {ctag, " oe_n"}, {31'd0, sram_oe_n}, {31'd0, e_oe});
    chk(sram_we_n == e_we, {ctag, " we_n"}, {31'd0, sram_we_n}, {31'd0, e_we});
    chk(sram_dq_oe == e_oe_drv, {ctag, " dq_oe"}, {31'd0, sram_dq_oe}, {31'd0, e_oe_drv});
    chk(sram_bsel_n == e_bsel, (mb == 2'b00) ? "R12 bsel_n" : "R5 bsel_n",
        {30'd0, sram_bsel_n}, {30'd0, e_bsel});
    if (!e_ce) chk(sram_addr == ma, "R10 sram_addr", {14'd0, sram_addr}, {14'd0, ma});
    if (e_oe_drv) chk(sram_dq_out == md, "R8 dq_out", {16'd0, sram_dq_out}, {16'd0, md});
    if (m_op == 1 && e_done)
      chk(rsp_rdata == m_exp, (mb != 2'b11) ? "R6 rsp_rdata" : "R4 rsp_rdata",
          {16'd0, rsp_rdata}, {16'd0, m_exp});

    prev_ready = e_ready;
    pv = req_valid; pw = req_write; pa = req_addr; pd = req_wdata; pb = req_be;

    // memory model drives the bus; lanes not selected float to a fixed pattern
    if (!sram_ce_n && sram_we_n && !sram_oe_n) begin
      logic [15:0] r;
      r = rd_word(mem, int'(sram_addr));
      sram_dq_in = {sram_bsel_n[1] ? 8'h5A : r[15:8], sram_bsel_n[0] ? 8'h5A : r[7:0]};
    end else sram_dq_in = 16'h5A5A;
  end

  task automatic issue(input bit w, input logic [17:0] a, input logic [15:0] d, input logic [1:0] be);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d; req_be = be;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #2;
    req_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    finished = 1'b1;
    $finish;
  endtask

  initial begin
    RDC = span(70);
    TAC = span(25);
    WPC = span(65);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(req_ready && sram_ce_n && sram_we_n && !sram_dq_oe, "R1 reset state",
        {28'd0, req_ready, sram_ce_n, sram_we_n, sram_dq_oe}, 32'hE);
    @(posedge clk); #2 rst_n = 1'b1;
    repeat (3) @(posedge clk); #2;
    // full-word write then read back (R3 R4 R8)
    issue(1, 18'h00010, 16'h1234, 2'b11);
    issue(0, 18'h00010, 16'h0000, 2'b11);
    // top address, lower byte only, then upper byte only (R5)
    issue(1, 18'h3FFFF, 16'hBEEF, 2'b01);
    issue(1, 18'h3FFFF, 16'hCA55, 2'b10);
    repeat (5) @(posedge clk); #2;
    issue(0, 18'h3FFFF, 16'h0000, 2'b11);
    // partial reads return zero in unselected lanes (R6)
    issue(0, 18'h3FFFF, 16'h0000, 2'b01);
    issue(0, 18'h3FFFF, 16'h0000, 2'b10);
    // empty mask: no byte strobe, memory untouched (R12)
    issue(1, 18'h00010, 16'hFFFF, 2'b00);
    issue(0, 18'h00010, 16'h0000, 2'b00);
    issue(0, 18'h00010, 16'h0000, 2'b11);
    // mixed back-to-back traffic, requests held while busy (R2)
    for (int i = 0; i < 24; i++)
      issue((i % 3) != 2, 18'h00020 + 18'(i % 4), 16'(i * 16'h1357 + 16'h2468), 2'(i % 4));
    for (int i = 0; i < 4; i++)
      issue(0, 18'h00020 + 18'(i), 16'h0000, 2'b11);
    repeat (20) @(posedge clk);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL R2 watchdog: actual hung expected completion");
      finish_run();
    end
  end

endmodule